// File: doc/BRIEF.md
# Post-Reset Acceleration Veto Gate

This block decides when an accelerator card may run the CPU from its own fast clock and memory. Every reset blocks acceleration. The block then watches the host bus for an access to the host's bus control register. The operating system's first access to that register is taken as its call to raise the host clock to full speed. That access lifts the block. From then on, the speed bit stored in that register decides whether acceleration is allowed.

The host starts in its slow 8 MHz mode. Switching from the fast clock down to 8 MHz hangs the system. So acceleration is allowed only while the stored speed bit selects 16 MHz. The output changes only while the address strobe is negated, so a transfer already under way never sees the enable move. Compared with a free-running delay counter after reset, this needs only a few flops: a veto bit, a speed bit, a capture flag and the enable register.

Top module: `accel_veto_gate`

## Requirements
- R1: While `rst` is high at a clock edge, `accel_en` becomes 0 after that edge. Reset sets the veto and the stored speed to 8 MHz (speed bit value 0).
- R2: After reset, `accel_en` stays 0 through any amount of bus traffic that does not access the register.
- R3: A register access needs `as_n` low and `addr` equal to `BCR_ADDR` in every bit. An address that differs in a single bit has no effect.
- R4: When the first register access after reset is a write (`rd_wr` = 0) with `spd_dat` = 1 (16 MHz), `accel_en` becomes 1 at the first clock edge at which `as_n` is sampled high after that access.
- R5: When the first register access after reset is a read (`rd_wr` = 1), the veto clears but the stored speed keeps its 8 MHz reset value, so `accel_en` stays 0. A later 16 MHz write then raises `accel_en`.
- R6: Every later register write stores `spd_dat` again. A 0 (8 MHz) drops `accel_en` and a 1 (16 MHz) raises it again, once the strobe is negated.
- R7: A register access is captured once per bus cycle, at the first clock edge with `as_n` low. A change of `spd_dat` later in the same strobe period is ignored.
- R8: `accel_en` changes only at clock edges at which `as_n` is sampled high.
- R9: A reset after acceleration was enabled blocks acceleration again until the next register access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Host address strobe, active low |
| addr | input | ADDR_W | Host address bus |
| rd_wr | input | 1 | 1 = read, 0 = write |
| spd_dat | input | 1 | Data line carrying the speed setting, 1 = 16 MHz |
| accel_en | output | 1 | Acceleration allowed |

## Verification
The assertions assume that `addr`, `rd_wr` and `spd_dat` are valid at the first clock edge with `as_n` low. They also assume that a bus cycle ends by negating the strobe for at least one edge. The properties on capture and release rely on that framing. The bench drives every input on the falling clock edge. It holds the strobe low for one to four edges and then returns it high for two idle edges. The random addresses are either the register address or arbitrary values. A directed case flips the data line partway through a strobe, which the design must ignore.

// File: rtl/accel_veto_pkg.sv
package accel_veto_pkg;

    typedef struct packed {
        logic hit;    // register accessed this bus cycle
        logic wr;     // access was a write
        logic fast;   // data line sampled at capture
    } reg_access_t;

    typedef enum logic {
        SPEED_8MHZ  = 1'b0,
        SPEED_16MHZ = 1'b1
    } host_speed_e;

    function automatic logic allow_accel(input logic vetoed, input host_speed_e spd);
        return !vetoed && (spd == SPEED_16MHZ);
    endfunction

endpackage

// File: rtl/bcr_access_detect.sv
module bcr_access_detect
    import accel_veto_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter logic [ADDR_W-1:0] BCR_ADDR = 24'hFF8007
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_wr,
    input  logic              spd_dat,
    output reg_access_t       acc
);
    logic taken_q;
    logic match;

    assign match = !as_n && (addr == BCR_ADDR);

    always_comb begin
        acc.hit  = match && !taken_q;
        acc.wr   = !rd_wr;
        acc.fast = spd_dat;
    end

    always_ff @(posedge clk) begin
        if (rst || as_n)
            taken_q <= 1'b0;
        else if (match)
            taken_q <= 1'b1;
    end
endmodule

// File: rtl/veto_state.sv
module veto_state
    import accel_veto_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  reg_access_t acc,
    output logic        veto_q,
    output host_speed_e speed_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            veto_q  <= 1'b1;
            speed_q <= SPEED_8MHZ;
        end else if (acc.hit) begin
            veto_q <= 1'b0;
            if (acc.wr)
                speed_q <= acc.fast ? SPEED_16MHZ : SPEED_8MHZ;
        end
    end
endmodule

// File: rtl/enable_gate.sv
module enable_gate
    import accel_veto_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        as_n,
    input  logic        veto,
    input  host_speed_e speed,
    output logic        en_q
);
    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (as_n)
            en_q <= allow_accel(veto, speed);
    end
endmodule

// File: rtl/accel_veto_gate.sv
module accel_veto_gate
    import accel_veto_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter logic [ADDR_W-1:0] BCR_ADDR = 24'hFF8007
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_wr,
    input  logic              spd_dat,
    output logic              accel_en
);
    reg_access_t acc;
    logic        veto_q;
    host_speed_e speed_q;

    bcr_access_detect #(.ADDR_W(ADDR_W), .BCR_ADDR(BCR_ADDR)) u_detect (
        .clk(clk), .rst(rst), .as_n(as_n), .addr(addr),
        .rd_wr(rd_wr), .spd_dat(spd_dat), .acc(acc)
    );

    veto_state u_state (
        .clk(clk), .rst(rst), .acc(acc), .veto_q(veto_q), .speed_q(speed_q)
    );

    enable_gate u_gate (
        .clk(clk), .rst(rst), .as_n(as_n), .veto(veto_q),
        .speed(speed_q), .en_q(accel_en)
    );
endmodule

// File: rtl/accel_veto_gate_chk.sv
module accel_veto_gate_chk #(
    parameter int ADDR_W = 24,
    parameter logic [ADDR_W-1:0] BCR_ADDR = 24'hFF8007
) (
    input logic              clk,
    input logic              rst,
    input logic              as_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_wr,
    input logic              accel_en,
    input logic              veto,
    input logic              speed
);
    AST_RESET_BLOCKS: assert property (@(posedge clk) rst |=> !accel_en); // R1

    AST_VETO_KEEPS_OFF: assert property (@(posedge clk) disable iff (rst)
        veto |-> !accel_en); // R2

    AST_MISS_KEEPS_VETO: assert property (@(posedge clk) disable iff (rst)
        (!as_n && addr != BCR_ADDR && veto) |=> veto); // R3

    AST_READ_KEEPS_SPEED: assert property (@(posedge clk) disable iff (rst)
        (!as_n && addr == BCR_ADDR && rd_wr) |=> $stable(speed)); // R5

    AST_ENABLE_BETWEEN_CYCLES: assert property (@(posedge clk) disable iff (rst)
        !as_n |=> $stable(accel_en)); // R8
endmodule

bind accel_veto_gate accel_veto_gate_chk #(.ADDR_W(ADDR_W), .BCR_ADDR(BCR_ADDR)) u_chk (
    .clk(clk), .rst(rst), .as_n(as_n), .addr(addr), .rd_wr(rd_wr),
    .accel_en(accel_en), .veto(veto_q), .speed(speed_q)
);

// File: tb/sim_accel_veto_gate.sv
`timescale 1ns/1ps
module sim_accel_veto_gate;
    localparam int ADDR_W = 24;
    localparam logic [ADDR_W-1:0] REG_A = 24'hFF8007;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic as_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic rd_wr = 1'b1;
    logic spd_dat = 1'b0;
    logic accel_en;

    int n_chk = 0;
    int n_fail = 0;
    bit exp_veto = 1'b1;
    bit exp_fast = 1'b0;
    bit exp_en = 1'b0;

    always #10 clk = ~clk;

    accel_veto_gate #(.ADDR_W(ADDR_W), .BCR_ADDR(REG_A)) u0 (
        .clk(clk), .rst(rst), .as_n(as_n), .addr(addr),
        .rd_wr(rd_wr), .spd_dat(spd_dat), .accel_en(accel_en)
    );

    function automatic bit want_en(input bit v, input bit f);
        return !v && f;
    endfunction

    task automatic check(input bit act, input bit expv, input string tag);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: accel_en=%0b expected %0b at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1; as_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(accel_en, 1'b0, tag);
        rst = 1'b0;
        exp_veto = 1'b1; exp_fast = 1'b0; exp_en = 1'b0;
        @(negedge clk);
        check(accel_en, 1'b0, tag);
    endtask

    // One bus cycle; flip_mid toggles the data line after the capture edge.
    task automatic bus_cycle(input logic [ADDR_W-1:0] a, input bit rd, input bit d,
                             input int hold, input bit flip_mid, input string tag);
        @(negedge clk);
        as_n = 1'b0; addr = a; rd_wr = rd; spd_dat = d;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(accel_en, exp_en, "R8");
            if (flip_mid) spd_dat = ~d;
        end
        if (a == REG_A) begin
            exp_veto = 1'b0;
            if (!rd) exp_fast = d;
        end
        as_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        exp_en = want_en(exp_veto, exp_fast);
        check(accel_en, exp_en, tag);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: accel_en=%0b expected completion", accel_en);
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset("R1");
        // R2: unrelated traffic, including fast-looking writes
        for (int i = 0; i < 6; i++)
            bus_cycle(REG_A ^ 24'h100000 ^ 24'(i), 1'b0, 1'b1, 2, 1'b0, "R2");
        // R3: single-bit neighbours of the register address
        for (int b = 0; b < ADDR_W; b += 5)
            bus_cycle(REG_A ^ (24'h1 << b), 1'b0, 1'b1, 1, 1'b0, "R3");
        // R4: first access writes 16 MHz
        bus_cycle(REG_A, 1'b0, 1'b1, 3, 1'b0, "R4");
        // R6: drop and raise
        bus_cycle(REG_A, 1'b0, 1'b0, 2, 1'b0, "R6");
        bus_cycle(REG_A, 1'b0, 1'b1, 1, 1'b0, "R6");
        // R9: reset after enable blocks again
        do_reset("R9");
        bus_cycle(24'h000123, 1'b1, 1'b1, 2, 1'b0, "R9");
        // R5: first access a read
        bus_cycle(REG_A, 1'b1, 1'b1, 2, 1'b0, "R5");
        bus_cycle(REG_A, 1'b0, 1'b1, 2, 1'b0, "R5");
        // R7: data changes mid-strobe are ignored
        bus_cycle(REG_A, 1'b0, 1'b0, 4, 1'b1, "R7");
        bus_cycle(REG_A, 1'b0, 1'b1, 4, 1'b1, "R7");
        // random traffic
        for (int i = 0; i < 60; i++) begin
            logic [ADDR_W-1:0] a;
            a = $urandom_range(0, 1) ? REG_A : ADDR_W'($urandom);
            bus_cycle(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      int'($urandom_range(1, 4)), 1'b0, "R6");
            if (i == 30) do_reset("R9");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule